// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Generator

This block drives one pulse-width modulated output per channel from a shared 1 MHz enable tick. Each channel keeps a period, a duty and a control value. The control value picks a power-of-two slow-down of the tick and an output inversion. Software programs the channel through a small word-addressed register port. Reads always return the values that were written most recently.

Duty and control writes are only staged. A period write arms a commit. A running channel then switches all three values together when its current period ends, so a waveform never mixes old and new settings. An idle channel starts at once. A period of zero stops the channel at the end of the running period, and the pin then rests low.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: Byte offsets of the registers, with n the channel index: period at 0x400+4n, duty at 0x420+4n, control at 0x440+4n. The counts use bits [15:0]. In the control register, bits [1:0] select the divider and bit 5 selects inversion; all other control bits read back as zero. A read returns the last value written.
- R3: The period write lands on one clock edge. An idle channel given a nonzero period keeps its output low through the following cycle, then starts with count 0 from the next edge.
- R4: The count runs from 0 to period-1 and wraps. The output is active while the count is below the duty and inactive for the rest of the period.
- R5: The count advances once every 2^d ticks of tick_i, where d is control bits [1:0].
- R6: With control bit 5 set, active means low and inactive means high.
- R7: A duty at or above the period keeps the output active for the whole period. A duty of 0 keeps it inactive.
- R8: While a channel runs, writes to its duty or control registers do not change its output until the period register is written.
- R9: After a period write to a running channel, the staged period, duty and control take effect together on the first period boundary, which is the edge where the count wraps to 0.
- R10: A committed period of 0 stops the channel at the boundary, and its output then stays low whatever the polarity. Writing 0 to the period of an idle channel leaves it idle and low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 MHz count enable, one clock wide |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high together with req_i |
| addr_i | input | 11 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
A period write registers an arm flag on its edge. The channel acts on the next edge. Outputs come straight from channel state, so an idle channel shows count 0 one cycle after the write cycle. A running channel shows new settings from the first boundary edge that falls at or after that next edge. The bench drives tick_i every clock and records the cycle of each write. From that cycle it computes the due cycle of every expected output bit and the boundary where a commit must land, and it queues each bit against its cycle number. The monitor compares at the falling edge, only items whose cycle number equals the current cycle. Read data is combinational and is compared within the cycle the address is applied.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W   = 11;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int DIV_W    = 2;
  localparam int INV_BIT  = 5;
  localparam int SLOT_W   = 3;            // 8 word slots per bank
  localparam int BANK_LSB = SLOT_W + 2;
  localparam logic [ADDR_W-1:0] OFF_PER  = 11'h400;
  localparam logic [ADDR_W-1:0] OFF_DUTY = 11'h420;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 11'h440;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] duty;
    logic [DIV_W-1:0] div;
    logic             inv;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output ch_cfg_t [NUM_CH-1:0] cfg_o,
  output logic [NUM_CH-1:0]    arm_o
);
  localparam int BANK_W = ADDR_W - BANK_LSB;

  logic [BANK_W-1:0] bank;
  logic [SLOT_W-1:0] slot;
  logic              aligned, sel_per, sel_duty, sel_ctrl, wr;

  assign bank     = addr_i[ADDR_W-1:BANK_LSB];
  assign slot     = addr_i[BANK_LSB-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign sel_per  = aligned && (bank == OFF_PER[ADDR_W-1:BANK_LSB]);
  assign sel_duty = aligned && (bank == OFF_DUTY[ADDR_W-1:BANK_LSB]);
  assign sel_ctrl = aligned && (bank == OFF_CTRL[ADDR_W-1:BANK_LSB]);
  assign wr       = req_i && we_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr && (slot == SLOT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[i] <= '0;
        arm_o[i] <= 1'b0;
      end else begin
        arm_o[i] <= hit && sel_per;
        if (hit && sel_per)  cfg_o[i].per  <= wdata_i[CNT_W-1:0];
        if (hit && sel_duty) cfg_o[i].duty <= wdata_i[CNT_W-1:0];
        if (hit && sel_ctrl) begin
          cfg_o[i].div <= wdata_i[DIV_W-1:0];
          cfg_o[i].inv <= wdata_i[INV_BIT];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (slot == SLOT_W'(c)) begin
        if (sel_per)  rdata_o[CNT_W-1:0] = cfg_o[c].per;
        if (sel_duty) rdata_o[CNT_W-1:0] = cfg_o[c].duty;
        if (sel_ctrl) begin
          rdata_o[DIV_W-1:0] = cfg_o[c].div;
          rdata_o[INV_BIT]   = cfg_o[c].inv;
        end
      end
    end
  end

  initial begin
    if (NUM_CH > (1 << SLOT_W)) $error("NUM_CH exceeds bank slots");
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;

  assign mask   = PRE_W'((1 << div_i) - 1);
  assign step_o = tick_i && (pre_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= step_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    arm_i,
  input  ch_cfg_t stg_i,
  output logic    pwm_o
);
  logic             run_q, pend_q, step, boundary, start, commit;
  logic [CNT_W-1:0] cnt_q;
  ch_cfg_t          act_q;

  pwm_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .tick_i (tick_i && run_q),
    .div_i  (act_q.div),
    .step_o (step)
  );

  assign start    = arm_i && !run_q && (stg_i.per != '0);
  assign boundary = run_q && step && (cnt_q == act_q.per - 1'b1);
  assign commit   = boundary && (pend_q || arm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      act_q  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      act_q  <= stg_i;
    end else if (run_q) begin
      if (step) cnt_q <= boundary ? '0 : cnt_q + 1'b1;
      if (commit) begin
        act_q  <= stg_i;
        run_q  <= (stg_i.per != '0);
        pend_q <= 1'b0;
      end else if (arm_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign pwm_o = run_q && ((cnt_q < act_q.duty) ^ act_q.inv);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < act_q.per)); // R4
  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (cnt_q == '0) && $past(arm_i)); // R3
  AST_SWAP_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(boundary || start)); // R9
  AST_STOP_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(boundary) && !pwm_o); // R10
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [10:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic    [NUM_CH-1:0] arm;

  pwm_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg),
    .arm_o   (arm)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .arm_i  (arm[i]),
      .stg_i  (cfg[i]),
      .pwm_o  (pwm_o[i])
    );
  end

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |=> (pwm_o == '0)); // R1
endmodule

// File: tb/pwm_shadow_ctrl_bench.sv
module pwm_shadow_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [3:0]  pwm_o;

  pwm_shadow_ctrl u_pwm_shadow_ctrl (
    .clk_i, .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .pwm_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int    cyc;
    int    ch;
    logic  val;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0, n_chk = 0, n_fail = 0;
  bit    done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare queued expectations due in this cycle
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.cyc != cyc || pwm_o[it.ch] !== it.val) begin
        n_fail++;
        $display("FAIL %s ch%0d cycle %0d: actual %b expected %b", it.tag, it.ch,
                 it.cyc, pwm_o[it.ch], it.val);
      end
    end
  end

  task automatic push(int c, int ch, logic v, string tag);
    item_t it;
    it.cyc = c; it.ch = ch; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wave(int ch, int c0, int from, int to, int per, int duty, int s,
                      bit inv, string tag);
    for (int c = from; c <= to; c++) begin
      int k;
      k = ((c - c0) / s) % per;
      push(c, ch, (k < duty) ^ inv, tag);
    end
  endtask

  function automatic int next_edge(int c0, int span, int w);
    return w + 1 + ((span - ((w + 1 - c0) % span)) % span);
  endfunction

  task automatic wr(logic [10:0] a, logic [31:0] d, output int w);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
    w = cyc;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_check(logic [10:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    addr_i = a;
    #1;
    n_chk++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s read 0x%0h: actual 0x%0h expected 0x%0h", tag, a, rdata_o, exp);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w, c0a, c0b, c0, e;
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    n_chk++;
    if (pwm_o !== 4'b0) begin
      n_fail++;
      $display("FAIL R1 pwm_o: actual %b expected 0000", pwm_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_check(11'h400 + 11'(4*i), 32'h0, "R1");
      rd_check(11'h420 + 11'(4*i), 32'h0, "R1");
      rd_check(11'h440 + 11'(4*i), 32'h0, "R1");
    end

    // R3 R4: idle start, period 5 duty 3
    wr(11'h420, 32'd3, w);
    wr(11'h440, 32'd0, w);
    wr(11'h400, 32'd5, w);
    c0a = w + 1;
    push(w, 0, 1'b0, "R3");
    push(c0a, 0, 1'b1, "R3");
    wave(0, c0a, c0a + 1, c0a + 14, 5, 3, 1, 1'b0, "R4");
    drain();

    // R8: staged duty/control do not touch the running output
    wr(11'h420, 32'd1, w);
    wr(11'h440, 32'h20, w);
    wave(0, c0a, w + 1, w + 10, 5, 3, 1, 1'b0, "R8");
    drain();
    rd_check(11'h420, 32'd1, "R2");
    rd_check(11'h440, 32'h20, "R2");

    // R9 R6: period write commits at the boundary, inverted from then on
    wr(11'h400, 32'd5, w);
    e = next_edge(c0a, 5, w);
    wave(0, c0a, w + 1, e - 1, 5, 3, 1, 1'b0, "R9");
    c0b = e;
    wave(0, c0b, e, e + 9, 5, 1, 1, 1'b1, "R9 R6");
    drain();

    // R7: duty above period is always active, duty 0 always inactive
    wr(11'h428, 32'd7, w);
    wr(11'h408, 32'd3, w);
    c0 = w + 1;
    wave(2, c0, c0, c0 + 8, 3, 7, 1, 1'b0, "R7");
    drain();
    wr(11'h428, 32'd0, w);
    wr(11'h408, 32'd3, w);
    e = next_edge(c0, 3, w);
    wave(2, c0, w + 1, e - 1, 3, 7, 1, 1'b0, "R7");
    wave(2, e, e, e + 5, 3, 0, 1, 1'b0, "R7");
    drain();

    // R5: divider code 2 -> one count per 4 ticks
    wr(11'h44C, 32'd2, w);
    wr(11'h42C, 32'd1, w);
    wr(11'h40C, 32'd2, w);
    c0 = w + 1;
    wave(3, c0, c0, c0 + 15, 2, 1, 4, 1'b0, "R5");
    drain();

    // R10: zero period stops at boundary, low despite inversion
    wr(11'h400, 32'd0, w);
    e = next_edge(c0b, 5, w);
    wave(0, c0b, w + 1, e - 1, 5, 1, 1, 1'b1, "R10");
    for (int c = e; c <= e + 9; c++) push(c, 0, 1'b0, "R10");
    drain();
    rd_check(11'h400, 32'd0, "R2");

    // R10: zero period on an idle inverted channel keeps it low
    wr(11'h444, 32'h20, w);
    wr(11'h424, 32'd2, w);
    wr(11'h404, 32'd0, w);
    for (int c = w + 1; c <= w + 8; c++) push(c, 1, 1'b0, "R10");
    drain();

    // R2: control readback masks unused bits, per-channel stride
    wr(11'h444, 32'hFF, w);
    rd_check(11'h444, 32'h23, "R2");
    rd_check(11'h40C, 32'd2, "R2");
    rd_check(11'h424, 32'd2, "R2");

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule